// File: doc/BRIEF.md
# NCO Control Register Bank

This block is the host-facing register interface of a phase-modulated numerically controlled oscillator. A host writes bytes over an 8-bit data bus with a 4-bit address. The bytes go into two 32-bit frequency-increment buffers (A and B) and into a 12-bit phase buffer. A rising edge on the write strobe stores a byte, but only while the active-low chip select is low. A pulse on the frequency load input copies the buffer named by the frequency select line into the active frequency register, which feeds the phase accumulator.

The phase word has two possible sources, chosen by the phase-source select line. One is the programmed phase buffer. The other is a raw 12-bit word taken straight from the address and data pins, which allows fast modulation without the write protocol. A pulse on the phase load input copies the chosen source into the active phase register.

All control inputs are asynchronous to the clock. Each one is synchronised and edge-detected before use.

Top module: `nco_ctrl_regs`

## Requirements
- R1: While `rst_n` is low, the active frequency word, the active phase word and all three buffers are cleared to zero. A load performed right after reset therefore yields zero.
- R2: A rising edge of `wr_strobe` while `cs_n` is low stores `bus_data` into the buffer byte selected by `bus_addr`. The byte becomes usable on the third rising clock edge after the strobe rises.
- R3: A strobe edge while `cs_n` is high writes nothing. No buffer changes.
- R4: Address bits [3:2] select the target buffer: 00 selects frequency buffer A, 01 selects frequency buffer B, and 1x selects the phase buffer.
- R5: For a frequency buffer, address bits [1:0] pick the byte lane: 00 is bits 7:0, 01 is bits 15:8, 10 is bits 23:16, and 11 is bits 31:24.
- R6: For the phase buffer, low address bits 00 store data bits 7:4 into phase bits 3:0, and low bits 01 store data bits 7:0 into phase bits 11:4. Low bits 10 and 11 change nothing.
- R7: Bytes may be written in any order. A byte that is not rewritten keeps its value.
- R8: A frequency load takes buffer A when `freq_sel` is high and buffer B when it is low.
- R9: A falling edge of `freq_load` updates `freq_word` on the fourth rising clock edge after the fall, and at no other time. Holding `freq_load` low does not cause a second update.
- R10: With `phase_src_sel` low, a phase load takes the word {`bus_data`, `bus_addr`}, so the data pins become phase bits 11:4 and the address pins become bits 3:0. This path does not depend on `wr_strobe` or `cs_n`.
- R11: With `phase_src_sel` high, a phase load takes the phase buffer.
- R12: A falling edge of `phase_load` updates `phase_word` on the fourth rising clock edge after the fall, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Host write data; phase bits 11:4 in bypass |
| bus_addr | input | 4 | Host byte address; phase bits 3:0 in bypass |
| cs_n | input | 1 | Active-low chip select qualifying writes |
| wr_strobe | input | 1 | Write strobe, rising edge stores a byte |
| freq_sel | input | 1 | High selects buffer A, low selects buffer B |
| freq_load | input | 1 | Frequency load request, falling edge active |
| phase_src_sel | input | 1 | High selects the phase buffer, low selects the pins |
| phase_load | input | 1 | Phase load request, falling edge active |
| freq_word | output | 32 | Active frequency increment |
| phase_word | output | 12 | Active phase offset |

## Verification
A byte write becomes usable on the third rising edge after the strobe rises. A load changes its output on the fourth rising edge after the request falls. The bench drives every input on the falling clock edge and keeps the bus and select lines stable until those edges have passed. For each load it reads the output once just after the third edge, where the old value must still be present, and once after the fourth edge, where the new value must have arrived. The effect of a write is only visible through a later load, so a write is always followed by a load before its result is compared with the bench's byte-level model of the buffers.

// File: rtl/nco_ctrl_pkg.sv
// Package: shared types and control-vector positions for the NCO control
// register bank. Assumes a 2-bit target field at the top of the address.
package nco_ctrl_pkg;

    typedef enum logic [1:0] {
        TGT_FREQ_A = 2'd0,
        TGT_FREQ_B = 2'd1,
        TGT_PHASE  = 2'd2
    } target_e;

    // Bit positions of the asynchronous controls inside the synchroniser vector
    localparam int CTL_CS   = 0;
    localparam int CTL_WR   = 1;
    localparam int CTL_FSEL = 2;
    localparam int CTL_FLD  = 3;
    localparam int CTL_PSEL = 4;
    localparam int CTL_PLD  = 5;
    localparam int CTL_NUM  = 6;

    // Idle levels: chip select and both loads idle high, the rest idle low
    localparam logic [CTL_NUM-1:0] CTL_IDLE = 6'b101001;

    // Map the two top address bits onto a target buffer
    function automatic target_e decode_target(input logic [1:0] hi);
        if (hi[1])      return TGT_PHASE;
        else if (hi[0]) return TGT_FREQ_B;
        else            return TGT_FREQ_A;
    endfunction

endpackage

// File: rtl/nco_sync_edge.sv
// Module: multi-bit synchroniser with edge detection.
// Each bit passes through STAGES flops. The last stage gives the level, and
// one more flop gives the previous level for rise and fall detection.
// Assumes every bit is an independent, slowly changing asynchronous control.
module nco_sync_edge #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] last;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            // Purpose: further metastability settling stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    // Purpose: keep the previous settled level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last <= RST_VAL;
        else        last <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last;
    assign fall  = ~chain[STAGES-1] & last;

endmodule

// File: rtl/nco_wr_bank.sv
// Module: byte-addressed write bank holding frequency buffers A and B and
// the phase buffer. A qualified write pulse stores one byte per pulse.
// Assumes the address and data are stable in the cycle of the pulse.
module nco_wr_bank
    import nco_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int FREQ_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        wr_addr,
    output logic [FREQ_W-1:0]        buf_a,
    output logic [FREQ_W-1:0]        buf_b,
    output logic [DATA_W+ADDR_W-1:0] buf_p,
    output logic [2:0]               tgt_we
);

    localparam int LANES   = FREQ_W / DATA_W;
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PH_LO_W = ADDR_W;

    target_e           tgt;
    logic [LANE_W-1:0] lane;
    logic [DATA_W-1:0] lane_a [LANES];
    logic [DATA_W-1:0] lane_b [LANES];
    logic [PH_LO_W-1:0] ph_lo;
    logic [DATA_W-1:0]  ph_hi;

    // Purpose: decode the target buffer and the lane for this write
    always_comb begin
        tgt    = decode_target(wr_addr[ADDR_W-1:ADDR_W-2]);
        lane   = wr_addr[LANE_W-1:0];
        tgt_we = '0;
        if (wr_fire) tgt_we[tgt] = 1'b1;
    end

    // Purpose: store byte lanes of frequency buffer A
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) lane_a[l] <= '0;
        end else if (tgt_we[TGT_FREQ_A]) begin
            for (int l = 0; l < LANES; l++)
                if (lane == LANE_W'(l)) lane_a[l] <= wr_data;
        end
    end

    // Purpose: store byte lanes of frequency buffer B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) lane_b[l] <= '0;
        end else if (tgt_we[TGT_FREQ_B]) begin
            for (int l = 0; l < LANES; l++)
                if (lane == LANE_W'(l)) lane_b[l] <= wr_data;
        end
    end

    // Purpose: store the two parts of the phase buffer; other lanes ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_lo <= '0;
            ph_hi <= '0;
        end else if (tgt_we[TGT_PHASE]) begin
            if (wr_addr[1:0] == 2'b00)      ph_lo <= wr_data[DATA_W-1 -: PH_LO_W];
            else if (wr_addr[1:0] == 2'b01) ph_hi <= wr_data;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_pack
        assign buf_a[l*DATA_W +: DATA_W] = lane_a[l];
        assign buf_b[l*DATA_W +: DATA_W] = lane_b[l];
    end

    assign buf_p = {ph_hi, ph_lo};

endmodule

// File: rtl/nco_load_stage.sv
// Module: two-step load path. In the cycle of the load event it captures
// the source; in the next cycle it moves the capture into the active register.
// Assumes the source is valid in the cycle of the event.
module nco_load_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] src,
    output logic [W-1:0] active,
    output logic         xfer
);

    logic [W-1:0] staged;
    logic         pending;

    // Purpose: capture the selected source on a load event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged  <= '0;
            pending <= 1'b0;
        end else begin
            pending <= fire;
            if (fire) staged <= src;
        end
    end

    // Purpose: move the captured word into the active register
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= '0;
        else if (pending) active <= staged;
    end

    assign xfer = pending;

endmodule

// File: rtl/nco_ctrl_regs.sv
// Module: top of the NCO control register bank. It synchronises the control
// inputs, writes the buffers and runs the frequency and phase load paths.
// Assumes the bus pins are held stable while a write or a bypass load is
// in progress.
module nco_ctrl_regs
    import nco_ctrl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int FREQ_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     cs_n,
    input  logic                     wr_strobe,
    input  logic                     freq_sel,
    input  logic                     freq_load,
    input  logic                     phase_src_sel,
    input  logic                     phase_load,
    output logic [FREQ_W-1:0]        freq_word,
    output logic [DATA_W+ADDR_W-1:0] phase_word
);

    localparam int PHASE_W = DATA_W + ADDR_W;

    logic [CTL_NUM-1:0] ctl_level, ctl_rise, ctl_fall;
    logic               wr_fire;
    logic [2:0]         tgt_we;
    logic [FREQ_W-1:0]  buf_a, buf_b, freq_src;
    logic [PHASE_W-1:0] buf_p, phase_src;
    logic               freq_xfer, phase_xfer;

    nco_sync_edge #(
        .WIDTH  (CTL_NUM),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({phase_load, phase_src_sel, freq_load, freq_sel, wr_strobe, cs_n}),
        .level   (ctl_level),
        .rise    (ctl_rise),
        .fall    (ctl_fall)
    );

    assign wr_fire = ctl_rise[CTL_WR] & ~ctl_level[CTL_CS];

    nco_wr_bank #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .FREQ_W(FREQ_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_fire(wr_fire),
        .wr_data(bus_data),
        .wr_addr(bus_addr),
        .buf_a  (buf_a),
        .buf_b  (buf_b),
        .buf_p  (buf_p),
        .tgt_we (tgt_we)
    );

    // Purpose: choose the frequency and phase sources from the settled selects
    always_comb begin
        freq_src  = ctl_level[CTL_FSEL] ? buf_a : buf_b;
        phase_src = ctl_level[CTL_PSEL] ? buf_p : {bus_data, bus_addr};
    end

    nco_load_stage #(.W(FREQ_W)) u_freq_load (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (ctl_fall[CTL_FLD]),
        .src   (freq_src),
        .active(freq_word),
        .xfer  (freq_xfer)
    );

    nco_load_stage #(.W(PHASE_W)) u_phase_load (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (ctl_fall[CTL_PLD]),
        .src   (phase_src),
        .active(phase_word),
        .xfer  (phase_xfer)
    );

endmodule

// File: rtl/nco_ctrl_regs_chk.sv
// Module: assertion checker for the NCO control register bank, bound to
// the top module. It relates the outputs to the transfer and write events.
module nco_ctrl_regs_chk #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FREQ_W-1:0]  freq_word,
    input logic [PHASE_W-1:0] phase_word,
    input logic               freq_xfer,
    input logic               phase_xfer,
    input logic [FREQ_W-1:0]  buf_a,
    input logic [FREQ_W-1:0]  buf_b,
    input logic               wr_fire,
    input logic [2:0]         tgt_we
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (freq_word == '0 && phase_word == '0));

    p_freq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_xfer |=> $stable(freq_word));

    p_freq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freq_xfer |=> !freq_xfer);

    p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_xfer |=> $stable(phase_word));

    p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> ($stable(buf_a) && $stable(buf_b)));

    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> ($countones(tgt_we) == 1));

endmodule

bind nco_ctrl_regs nco_ctrl_regs_chk #(
    .FREQ_W (FREQ_W),
    .PHASE_W(PHASE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .phase_word(phase_word),
    .freq_xfer (freq_xfer),
    .phase_xfer(phase_xfer),
    .buf_a     (buf_a),
    .buf_b     (buf_b),
    .wr_fire   (wr_fire),
    .tgt_we    (tgt_we)
);

// File: tb/nco_ctrl_regs_tb_top.sv
// Bench: directed corner cases plus seeded random writes and loads, checked
// against a byte-level model of the buffers kept in the bench.
module nco_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [3:0]  bus_addr = '0;
    logic        cs_n = 1'b1;
    logic        wr_strobe = 1'b0;
    logic        freq_sel = 1'b0;
    logic        freq_load = 1'b1;
    logic        phase_src_sel = 1'b0;
    logic        phase_load = 1'b1;
    logic [31:0] freq_word;
    logic [11:0] phase_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_a = '0, m_b = '0;
    logic [11:0] m_p = '0;

    always #4 clk = ~clk;

    nco_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .cs_n(cs_n), .wr_strobe(wr_strobe), .freq_sel(freq_sel),
        .freq_load(freq_load), .phase_src_sel(phase_src_sel),
        .phase_load(phase_load), .freq_word(freq_word), .phase_word(phase_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Model of one stored byte, following R4, R5 and R6
    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a[3]) begin
            if (a[1:0] == 2'b00)      m_p[3:0]  = d[7:4];
            else if (a[1:0] == 2'b01) m_p[11:4] = d;
        end else if (a[2]) begin
            m_b[a[1:0]*8 +: 8] = d;
        end else begin
            m_a[a[1:0]*8 +: 8] = d;
        end
    endtask

    task automatic write_byte(input logic [3:0] a, input logic [7:0] d, input logic sel_low);
        @(negedge clk);
        bus_addr = a; bus_data = d; cs_n = ~sel_low;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b1;
        repeat (4) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        if (sel_low) model_write(a, d);
    endtask

    // Frequency load: old value after 3 edges, new value after the 4th
    task automatic load_freq(input logic sel, input string tag);
        logic [31:0] old, exp;
        @(negedge clk);
        freq_sel = sel;
        repeat (3) @(negedge clk);
        old = freq_word;
        exp = sel ? m_a : m_b;
        freq_load = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " R9 not yet"}, freq_word, old);
        @(negedge clk);
        check(tag, freq_word, exp);
        freq_load = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_phase(input logic src, input logic [11:0] pins, input string tag);
        logic [11:0] old, exp;
        @(negedge clk);
        phase_src_sel = src;
        if (!src) begin
            bus_data = pins[11:4];
            bus_addr = pins[3:0];
        end
        repeat (3) @(negedge clk);
        old = phase_word;
        exp = src ? m_p : pins;
        phase_load = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " R12 not yet"}, {20'd0, phase_word}, {20'd0, old});
        @(negedge clk);
        check(tag, {20'd0, phase_word}, {20'd0, exp});
        phase_load = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check("R1 freq reset", freq_word, 32'd0);
        check("R1 phase reset", {20'd0, phase_word}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        load_freq(1'b1, "R1 buffer A cleared");
        load_freq(1'b0, "R1 buffer B cleared");
        load_phase(1'b1, 12'h000, "R1 phase buffer cleared");

        // R5 R7: lanes written out of order
        write_byte(4'b0011, 8'h12, 1'b1);
        write_byte(4'b0000, 8'h78, 1'b1);
        write_byte(4'b0010, 8'h34, 1'b1);
        write_byte(4'b0001, 8'h56, 1'b1);
        // R4: buffer B
        write_byte(4'b0100, 8'hEF, 1'b1);
        write_byte(4'b0101, 8'hBE, 1'b1);
        write_byte(4'b0110, 8'hAD, 1'b1);
        write_byte(4'b0111, 8'hDE, 1'b1);
        load_freq(1'b1, "R2 R5 R8 buffer A");
        check("R5 lane order", freq_word, 32'h12345678);
        load_freq(1'b0, "R4 R8 buffer B");
        check("R4 buffer B value", freq_word, 32'hDEADBEEF);

        // R3: chip select high blocks the write
        write_byte(4'b0010, 8'hFF, 1'b0);
        load_freq(1'b1, "R3 cs high ignored");

        // R7: only lane 0 rewritten
        write_byte(4'b0000, 8'h99, 1'b1);
        load_freq(1'b1, "R7 other lanes kept");

        // R6: phase buffer parts, unused lanes ignored
        write_byte(4'b1000, 8'hAB, 1'b1);
        write_byte(4'b1101, 8'hCD, 1'b1);
        write_byte(4'b1010, 8'hFF, 1'b1);
        write_byte(4'b1011, 8'h77, 1'b1);
        load_phase(1'b1, 12'h000, "R6 R11 phase buffer");
        check("R6 phase value", {20'd0, phase_word}, 32'h00000CDA);

        // R10: bypass with chip select low and idle strobe, buffers untouched
        @(negedge clk); cs_n = 1'b0;
        load_phase(1'b0, 12'h5A3, "R10 pin bypass");
        @(negedge clk); cs_n = 1'b1;
        load_phase(1'b1, 12'h000, "R10 buffer untouched");

        // R9: request held low, buffer changes, no second update
        @(negedge clk); freq_sel = 1'b1;
        repeat (3) @(negedge clk);
        freq_load = 1'b0;
        repeat (6) @(negedge clk);
        held = freq_word;
        check("R9 first update", held, m_a);
        write_byte(4'b0001, 8'h11, 1'b1);
        repeat (6) @(negedge clk);
        check("R9 no repeat while low", freq_word, held);
        freq_load = 1'b1;
        repeat (4) @(negedge clk);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 6)
                write_byte(4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
                           ($urandom_range(0, 9) < 8));
            else if (op < 8)
                load_freq(1'($urandom_range(0, 1)), "R8 random freq load");
            else if (op == 8)
                load_phase(1'b1, 12'h000, "R11 random phase load");
            else
                load_phase(1'b0, 12'($urandom_range(0, 4095)), "R10 random bypass");
        end
        finish_run();
    end

endmodule